// File: doc/BRIEF.md
# Serial Configuration EEPROM Loader

After power-up, this block reads a range of 16-bit words from a three-wire serial EEPROM and passes each word to the chip's configuration registers. It waits until the supply-good input has been high for a fixed settling time. It then reads the words one at a time, in ascending address order. For each word it raises chip select, shifts out a read frame, and shifts in the returned data. The words it delivers are not checked and nothing is ever written back to the EEPROM.

All serial timing comes from a tick. The tick is produced by a prescaler that divides the system clock by a run-time value. The tick period is meant to be set to at least 1 us. With that setting:

- the serial clock period is four ticks, which is at least 4 us;
- setup, hold and sample points sit two ticks from the clock edge they relate to;
- chip select leads the first clock edge by more than one tick.

The overall time budget is checked when the design is elaborated.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While the synchronous reset is asserted, and in the cycle after it, `ee_cs`, `ee_sck`, `ee_cmd_out`, `cfg_valid` and `cfg_done` are all 0. Leaving reset starts a new supply wait.
- R2: A tick occurs once every `prescale`+1 system clocks. Inside a word, the serial clock is low for two ticks and then high for two ticks, so rising edges are exactly 4·(`prescale`+1) clocks apart.
- R3: `ee_cs` stays low until `pwr_ok` has been high without a break for at least `PWR_TICKS` tick periods. If `pwr_ok` drops during the wait, the wait starts again.
- R4: The first rising edge of `ee_sck` comes at least one tick period after `ee_cs` rises.
- R5: `ee_cmd_out` changes only while `ee_sck` is low. Each change is at least two tick periods after the previous rising edge and at least two tick periods before the next one.
- R6: Each word starts with a 9-bit frame on `ee_cmd_out`, one bit per rising edge, MSB first: a start bit of 1, then opcode bits 1 and 0, then the 6-bit word address.
- R7: `ee_rd_in` is sampled at each falling edge, two ticks after the rising edge. The sample taken at the last frame bit is a placeholder and its value has no effect. The next 16 samples form the data word, MSB first.
- R8: `ee_sck` toggles only while `ee_cs` is high. `ee_cs` falls at least two tick periods after the last falling edge of the word, and stays low for at least two tick periods before the next word.
- R9: For each word, `cfg_valid` is high for one cycle while `ee_cs` is low. In that cycle `cfg_addr` holds the word's address and `cfg_data` holds the word.
- R10: Addresses `FIRST_ADDR` to `LAST_ADDR` are each delivered once, in ascending order. `cfg_done` rises in the cycle after the last strobe and stays high until reset, with no further strobes.
- R11: From the last rise of `pwr_ok`, the whole load ends within `BUDGET_TICKS` tick periods. A parameter set that cannot meet this fails elaboration.
- R12: A reset during a load abandons it. The next load starts again at `FIRST_ADDR` and delivers the full range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| prescale | input | PRE_W | Tick divider; one tick every prescale+1 clocks |
| pwr_ok | input | 1 | Supply reported stable |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sck | output | 1 | EEPROM serial clock |
| ee_cmd_out | output | 1 | Serial data from the loader to the EEPROM |
| ee_rd_in | input | 1 | Serial data from the EEPROM to the loader |
| cfg_valid | output | 1 | One-cycle word strobe |
| cfg_addr | output | ADDR_W | Address of the strobed word |
| cfg_data | output | DATA_W | Strobed data word |
| cfg_done | output | 1 | All configured words delivered |

## Verification
The serial edges are registered on tick cycles, so each timing result falls a whole number of tick periods after its cause. Rising edges are due exactly four ticks apart. Data and chip-select changes are due at least two ticks from the edges they guard. Chip select is due more than one tick before the first clock, and more than `PWR_TICKS` ticks after the supply comes up. A cycle-stamping monitor samples on the falling system clock edge and measures each of these distances against the tick length for the prescale value under test. That sweep covers four prescale values. Word strobes are checked in the cycle they appear, against an address count and a data formula computed in the bench. The done flag is checked in exactly the cycle after the final strobe.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

   typedef enum logic [2:0] {
      RD_IDLE,
      RD_LEAD,
      RD_SHIFT,
      RD_TRAIL,
      RD_GAP
   } rd_state_t;

   typedef enum logic [1:0] {
      SQ_WAIT,
      SQ_ISSUE,
      SQ_BUSY,
      SQ_DONE
   } seq_state_t;

   // start bit followed by the two-bit read opcode
   localparam logic [2:0] READ_HEAD = 3'b110;

endpackage

// File: rtl/eecfg_tick_gen.sv
module eecfg_tick_gen #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PRE_W-1:0] prescale,
   output logic             tick
);

   generate
      if (PRE_W < 1) begin : g_bad_width
         $error("eecfg_tick_gen: PRE_W must be at least 1");
      end
   endgenerate

   logic [PRE_W-1:0] cnt_q;

   assign tick = (cnt_q >= prescale);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/eecfg_word_reader.sv
module eecfg_word_reader
   import eecfg_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int GUARD_TICKS = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   output logic              cs,
   output logic              sck,
   output logic              cmd_out,
   input  logic              rd_in,
   output logic              word_valid,
   output logic [DATA_W-1:0] word_data
);

   localparam int CMD_BITS   = 3 + ADDR_W;
   localparam int FRAME_BITS = CMD_BITS + DATA_W;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam int GC_W       = $clog2(GUARD_TICKS + 1);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("eecfg_word_reader: DATA_W must be at least 2");
      end
      if (GUARD_TICKS < 2) begin : g_bad_guard
         $error("eecfg_word_reader: GUARD_TICKS below the two-tick rule");
      end
   endgenerate

   rd_state_t            state_q;
   logic [1:0]           ph_q;
   logic [IDX_W-1:0]     idx_q;
   logic [GC_W-1:0]      gcnt_q;
   logic [CMD_BITS-1:0]  cmd_q;
   logic [DATA_W-1:0]    data_q;
   logic                 guard_end;
   logic                 in_cmd;

   assign guard_end = (gcnt_q == GC_W'(GUARD_TICKS - 1));
   assign in_cmd    = (state_q == RD_LEAD) ||
                      ((state_q == RD_SHIFT) && (idx_q < IDX_W'(CMD_BITS)));
   assign cmd_out   = in_cmd && cmd_q[CMD_BITS-1];
   assign word_data = data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= RD_IDLE;
         ph_q       <= '0;
         idx_q      <= '0;
         gcnt_q     <= '0;
         cmd_q      <= '0;
         data_q     <= '0;
         cs         <= 1'b0;
         sck        <= 1'b0;
         word_valid <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         unique case (state_q)
            RD_IDLE: begin
               if (start) begin
                  cmd_q   <= {READ_HEAD, addr};
                  cs      <= 1'b1;
                  gcnt_q  <= '0;
                  state_q <= RD_LEAD;
               end
            end
            RD_LEAD: begin
               if (tick) begin
                  if (guard_end) begin
                     gcnt_q  <= '0;
                     ph_q    <= '0;
                     idx_q   <= '0;
                     state_q <= RD_SHIFT;
                  end else begin
                     gcnt_q <= gcnt_q + 1'b1;
                  end
               end
            end
            RD_SHIFT: begin
               if (tick) begin
                  ph_q <= ph_q + 2'd1;
                  if (ph_q == 2'd1) begin
                     sck <= 1'b1;
                  end
                  if (ph_q == 2'd3) begin
                     sck   <= 1'b0;
                     cmd_q <= {cmd_q[CMD_BITS-2:0], 1'b0};
                     if (idx_q >= IDX_W'(CMD_BITS)) begin
                        data_q <= {data_q[DATA_W-2:0], rd_in};
                     end
                     if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
                        gcnt_q  <= '0;
                        state_q <= RD_TRAIL;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                     end
                  end
               end
            end
            RD_TRAIL: begin
               if (tick) begin
                  if (guard_end) begin
                     gcnt_q  <= '0;
                     cs      <= 1'b0;
                     state_q <= RD_GAP;
                  end else begin
                     gcnt_q <= gcnt_q + 1'b1;
                  end
               end
            end
            RD_GAP: begin
               if (tick) begin
                  if (guard_end) begin
                     gcnt_q     <= '0;
                     word_valid <= 1'b1;
                     state_q    <= RD_IDLE;
                  end else begin
                     gcnt_q <= gcnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
   import eecfg_pkg::*;
#(
   parameter int ADDR_W       = 6,
   parameter int DATA_W       = 16,
   parameter int FIRST_ADDR   = 0,
   parameter int LAST_ADDR    = 15,
   parameter int PRE_W        = 8,
   parameter int PWR_TICKS    = 60,
   parameter int BUDGET_TICKS = 2000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PRE_W-1:0]  prescale,
   input  logic              pwr_ok,
   output logic              ee_cs,
   output logic              ee_sck,
   output logic              ee_cmd_out,
   input  logic              ee_rd_in,
   output logic              cfg_valid,
   output logic [ADDR_W-1:0] cfg_addr,
   output logic [DATA_W-1:0] cfg_data,
   output logic              cfg_done
);

   localparam int GUARD      = 2;
   localparam int NWORDS     = LAST_ADDR - FIRST_ADDR + 1;
   localparam int FRAME_BITS = 3 + ADDR_W + DATA_W;
   localparam int WORD_TICKS = 3 * GUARD + 4 * FRAME_BITS + 2;
   localparam int LOAD_TICKS = PWR_TICKS + 1 + NWORDS * WORD_TICKS;
   localparam int WC_W       = $clog2(PWR_TICKS + 1);

   generate
      if (LAST_ADDR < FIRST_ADDR || FIRST_ADDR < 0) begin : g_bad_range
         $error("eeprom_cfg_loader: empty or negative address range");
      end
      if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_last
         $error("eeprom_cfg_loader: LAST_ADDR does not fit ADDR_W");
      end
      if (PWR_TICKS < 1) begin : g_bad_wait
         $error("eeprom_cfg_loader: PWR_TICKS must be positive");
      end
      if (LOAD_TICKS > BUDGET_TICKS) begin : g_over_budget
         $error("eeprom_cfg_loader: worst-case load exceeds BUDGET_TICKS");
      end
   endgenerate

   seq_state_t        sq_q;
   logic [WC_W-1:0]   wcnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic              tick;
   logic              rd_start;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;

   eecfg_tick_gen #(
      .PRE_W(PRE_W)
   ) u_tick (
      .clk      (clk),
      .rst      (rst),
      .prescale (prescale),
      .tick     (tick)
   );

   eecfg_word_reader #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .GUARD_TICKS (GUARD)
   ) u_reader (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .start      (rd_start),
      .addr       (addr_q),
      .cs         (ee_cs),
      .sck        (ee_sck),
      .cmd_out    (ee_cmd_out),
      .rd_in      (ee_rd_in),
      .word_valid (rd_valid),
      .word_data  (rd_data)
   );

   assign rd_start  = (sq_q == SQ_ISSUE);
   assign cfg_valid = rd_valid;
   assign cfg_addr  = addr_q;
   assign cfg_data  = rd_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         sq_q     <= SQ_WAIT;
         wcnt_q   <= '0;
         addr_q   <= ADDR_W'(FIRST_ADDR);
         cfg_done <= 1'b0;
      end else begin
         unique case (sq_q)
            SQ_WAIT: begin
               if (!pwr_ok) begin
                  wcnt_q <= '0;
               end else if (tick) begin
                  if (wcnt_q == WC_W'(PWR_TICKS)) begin
                     addr_q <= ADDR_W'(FIRST_ADDR);
                     sq_q   <= SQ_ISSUE;
                  end else begin
                     wcnt_q <= wcnt_q + 1'b1;
                  end
               end
            end
            SQ_ISSUE: sq_q <= SQ_BUSY;
            SQ_BUSY: begin
               if (rd_valid) begin
                  if (addr_q == ADDR_W'(LAST_ADDR)) begin
                     cfg_done <= 1'b1;
                     sq_q     <= SQ_DONE;
                  end else begin
                     addr_q <= addr_q + 1'b1;
                     sq_q   <= SQ_ISSUE;
                  end
               end
            end
            SQ_DONE: sq_q <= SQ_DONE;
            default: sq_q <= SQ_WAIT;
         endcase
      end
   end

endmodule

// File: rtl/eecfg_checker.sv
module eecfg_checker (
   input logic clk,
   input logic rst,
   input logic ee_cs,
   input logic ee_sck,
   input logic ee_cmd_out,
   input logic cfg_valid,
   input logic cfg_done
);

   // R1: outputs quiet in the cycle after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!ee_cs && !ee_sck && !ee_cmd_out && !cfg_valid && !cfg_done));

   // R8: serial clock only under select
   a_r8_sck_needs_cs: assert property (@(posedge clk) disable iff (rst)
      ee_sck |-> ee_cs);

   // R8: select never drops while the clock was high
   a_r8_cs_drop_low: assert property (@(posedge clk) disable iff (rst)
      $fell(ee_cs) |-> !$past(ee_sck));

   // R5: outgoing data held while the clock is high
   a_r5_data_hold: assert property (@(posedge clk) disable iff (rst)
      ($past(ee_sck) && ee_sck) |-> $stable(ee_cmd_out));

   // R9: strobe is a single cycle
   a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
      cfg_valid |=> !cfg_valid);

   // R9: strobe only while deselected
   a_r9_strobe_deselected: assert property (@(posedge clk) disable iff (rst)
      cfg_valid |-> !ee_cs);

   // R10: done is sticky
   a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
      cfg_done |=> cfg_done);

   // R10: nothing more after done
   a_r10_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
      cfg_done |-> (!cfg_valid && !ee_cs));

endmodule

bind eeprom_cfg_loader eecfg_checker u_chk (.*);

// File: tb/eeprom_cfg_loader_bench.sv
module eeprom_cfg_loader_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 6;
   localparam int DATA_W     = 16;
   localparam int FIRST      = 3;
   localparam int LAST       = 10;
   localparam int NW         = LAST - FIRST + 1;
   localparam int PRE_W      = 4;
   localparam int PWR        = 12;
   localparam int BUDGET     = 2000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [PRE_W-1:0]  prescale = '0;
   logic              pwr_ok = 1'b0;
   logic              ee_cs, ee_sck, ee_cmd_out;
   logic              ee_rd_in = 1'b0;
   logic              cfg_valid, cfg_done;
   logic [ADDR_W-1:0] cfg_addr;
   logic [DATA_W-1:0] cfg_data;

   int total = 0;
   int bad   = 0;
   int tk    = 1;
   logic dummy_val = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eeprom_cfg_loader #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIRST_ADDR(FIRST), .LAST_ADDR(LAST),
      .PRE_W(PRE_W), .PWR_TICKS(PWR), .BUDGET_TICKS(BUDGET)
   ) u_eeprom_cfg_loader (
      .clk(clk), .rst(rst), .prescale(prescale), .pwr_ok(pwr_ok),
      .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_cmd_out(ee_cmd_out), .ee_rd_in(ee_rd_in),
      .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_done(cfg_done)
   );

   function automatic logic [15:0] exp_word(int a);
      return 16'(a * 945) ^ 16'hC35A;
   endfunction

   // EEPROM model: frame in on rising edges, placeholder then data out
   int          rc = 0;
   logic [7:0]  m_sr = '0;
   logic [15:0] m_word = '0;
   int          m_err = 0;
   always @(posedge ee_sck or negedge ee_cs) begin
      if (!ee_cs) begin
         rc = 0;
      end else begin
         if (rc < 8) begin
            m_sr = {m_sr[6:0], ee_cmd_out};
         end else if (rc == 8) begin
            if ({m_sr[7:6], m_sr[5]} != 3'b110) m_err++;
            m_word = exp_word(int'({m_sr[4:0], ee_cmd_out}));
            ee_rd_in <= dummy_val;
         end else if (rc <= 24) begin
            ee_rd_in <= m_word[15 - (rc - 9)];
         end
         rc = rc + 1;
      end
   end

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // timing and output monitor, sampled away from the active edge
   int v_wait, v_gap, v_lead, v_per, v_setup, v_hold, v_trail, v_sel, v_strobe, v_seq, v_done, v_budget;
   int n_words, t_pwr, t_csr, t_csf, t_rise, t_fall, t_di, t_val;
   bit first_cs, have_rise;
   logic p_cs, p_sck, p_di, p_pwr, p_valid, p_done;
   always @(negedge clk) begin
      if (rst) begin
         v_wait = 0; v_gap = 0; v_lead = 0; v_per = 0; v_setup = 0; v_hold = 0;
         v_trail = 0; v_sel = 0; v_strobe = 0; v_seq = 0; v_done = 0; v_budget = 0;
         n_words = 0; t_pwr = cyc; t_csr = cyc; t_csf = cyc - 1000; t_rise = cyc;
         t_fall = cyc; t_di = cyc; t_val = cyc; first_cs = 1; have_rise = 0;
      end else begin
         if (pwr_ok && !p_pwr) t_pwr = cyc;
         if (ee_cs && !p_cs) begin
            if (first_cs) begin
               if (!pwr_ok || (cyc - t_pwr) < PWR * tk) v_wait++;
               first_cs = 0;
            end else if ((cyc - t_csf) < 2 * tk) v_gap++;
            t_csr = cyc; have_rise = 0;
         end
         if (ee_cmd_out != p_di) begin
            if (ee_sck) v_hold++;
            else if (have_rise && (cyc - t_rise) < 2 * tk) v_hold++;
            t_di = cyc;
         end
         if (ee_sck && !p_sck) begin
            if (!ee_cs) v_sel++;
            if (!have_rise) begin
               if ((cyc - t_csr) < tk) v_lead++;
            end else if ((cyc - t_rise) != 4 * tk) v_per++;
            if ((cyc - t_di) < 2 * tk) v_setup++;
            t_rise = cyc; have_rise = 1;
         end
         if (!ee_sck && p_sck) t_fall = cyc;
         if (!ee_cs && p_cs) begin
            if ((cyc - t_fall) < 2 * tk) v_trail++;
            t_csf = cyc;
         end
         if (cfg_valid) begin
            if (p_valid || ee_cs) v_strobe++;
            if (int'(cfg_addr) != FIRST + n_words || cfg_data != exp_word(int'(cfg_addr))) v_seq++;
            n_words++; t_val = cyc;
         end
         if (cfg_done && !p_done) begin
            if (n_words == 0 || cyc != t_val + 1) v_done++;
            if ((cyc - t_pwr) > BUDGET * tk) v_budget++;
         end
      end
      p_cs = ee_cs; p_sck = ee_sck; p_di = ee_cmd_out; p_pwr = pwr_ok;
      p_valid = cfg_valid; p_done = cfg_done;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_done();
      int n;
      n = 0;
      while (!cfg_done && n < 40000) begin
         @(negedge clk);
         n++;
      end
      check(cfg_done === 1'b1, "R10 watchdog: load did not finish", int'(cfg_done), 1);
   endtask

   task automatic run_load(input int p, input bit dmy, input bit glitch, input bit mid_rst);
      int err0, n;
      tk = p + 1; prescale = PRE_W'(p); dummy_val = dmy;
      err0 = m_err;
      pwr_ok = 1'b0; rst = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({ee_cs, ee_sck, ee_cmd_out, cfg_valid, cfg_done} == 5'b0, "R1 reset outputs",
            int'({ee_cs, ee_sck, ee_cmd_out, cfg_valid, cfg_done}), 0);
      rst = 1'b0;
      repeat (PWR * tk + 20) @(negedge clk);
      // R3 no access without supply
      check(ee_cs == 1'b0, "R3 select before supply good", int'(ee_cs), 0);
      pwr_ok = 1'b1;
      if (glitch) begin
         repeat (PWR * tk / 2 + 1) @(negedge clk);
         pwr_ok = 1'b0;
         repeat (3) @(negedge clk);
         pwr_ok = 1'b1;
      end
      if (mid_rst) begin
         n = 0;
         while (n_words < 3 && n < 20000) begin @(negedge clk); n++; end
         repeat (7 * tk) @(negedge clk);
         rst = 1'b1;
         repeat (2) @(negedge clk);
         // R12 abandon on reset
         check({ee_cs, ee_sck, cfg_valid, cfg_done} == 4'b0, "R12 reset mid-load",
               int'({ee_cs, ee_sck, cfg_valid, cfg_done}), 0);
         rst = 1'b0;
      end
      wait_done();
      check(v_wait == 0,   "R3 supply wait",         v_wait, 0);
      check(v_per == 0,    "R2 serial clock period", v_per, 0);
      check(v_lead == 0,   "R4 select lead",         v_lead, 0);
      check(v_setup == 0,  "R5 data setup",          v_setup, 0);
      check(v_hold == 0,   "R5 data hold",           v_hold, 0);
      check(m_err == err0, "R6 start and opcode",    m_err - err0, 0);
      check(v_seq == 0,    "R7 R12 word contents",   v_seq, 0);
      check(v_trail + v_gap + v_sel == 0, "R8 select hold/gap", v_trail + v_gap + v_sel, 0);
      check(v_strobe == 0, "R9 strobe shape",        v_strobe, 0);
      check(n_words == NW, "R10 word count",         n_words, NW);
      check(v_done == 0,   "R10 done timing",        v_done, 0);
      check(v_budget == 0, "R11 load budget",        v_budget, 0);
      repeat (10 * tk) @(negedge clk);
      check(cfg_done && !ee_cs && n_words == NW, "R10 done holds", n_words, NW);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      run_load(0, 1'b0, 1'b0, 1'b0);
      run_load(1, 1'b1, 1'b1, 1'b0);   // R7 placeholder driven 1, R3 supply glitch
      run_load(3, 1'b0, 1'b0, 1'b1);   // R12 reset mid-load
      run_load(2, 1'b1, 1'b0, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule